// File: doc/BRIEF.md
# Chunked Outbound Address Window Decoder

This block sits between a CPU-side address bus and a downstream expansion bus. For every CPU address it answers one question: should this access be forwarded downstream or served locally? The top 256 MiB of the 32-bit space is cut into thirty-two 8 MiB chunks. A 32-bit enable register holds one bit per chunk. A two-bit mode field, stored from bits 8:7 of a control write, gates all forwarding at once. The lowest chunk holds firmware and the highest chunk holds the bridge's own registers, so neither is ever forwarded, whatever its enable bit says.

In the other direction, addresses issued by downstream bus masters are sorted into one of three targets. System memory covers everything below the second chunk. Downstream memory covers the thirty middle chunks. CPU-local space is the topmost 1 MiB. Any other inbound address is flagged as a decode error. Both lookups are purely combinational from the address inputs and the two registers, so a configuration write is visible from the clock edge that stores it.

Top module: `chunk_window_decoder`

## Requirements
- R1: Synchronous active-high reset clears the enable register and the mode field to zero, so no address is forwarded after reset.
- R2: Forwarding happens only while the mode field equals binary 01. The mode field is written from bits 8:7 of a control write. The values 00, 10 and 11 block every window.
- R3: With forwarding on, an address in [0xF0000000 + i*8 MiB, 0xF0000000 + (i+1)*8 MiB - 1] for i from 1 to 30 is forwarded exactly when enable bit i is set.
- R4: Enable bits 0 and 31 have no effect: chunks 0xF0000000-0xF07FFFFF and 0xFF800000-0xFFFFFFFF are never forwarded.
- R5: Addresses below 0xF0000000 are never forwarded.
- R6: `ob_local` is the complement of `ob_fwd` for every address.
- R7: A write sets its register at the next rising clock edge. A lookup in the same cycle as the write still sees the old value, and lookups in later cycles see the new one.
- R8: An inbound address below 0xF0800000 selects system memory (`ib_route` = 3'b001).
- R9: An inbound address from 0xF0800000 to 0xFF7FFFFF selects downstream memory (`ib_route` = 3'b010).
- R10: An inbound address from 0xFFF00000 to 0xFFFFFFFF selects CPU-local space (`ib_route` = 3'b100).
- R11: An inbound address from 0xFF800000 to 0xFFEFFFFF raises `ib_err` with `ib_route` = 0. Exactly one of the four inbound outputs is high at any time.
- R12: `cfg_sel` = 0 writes the enable register and `cfg_sel` = 1 writes the mode field. A write to one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: enable register, 1: control (mode in bits 8:7) |
| cfg_wdata | input | 32 | Configuration write data |
| ob_addr | input | 32 | CPU-side address to classify |
| ob_fwd | output | 1 | Address falls in an enabled, forwardable chunk |
| ob_local | output | 1 | Address stays on the local side |
| ib_addr | input | 32 | Address from a downstream master |
| ib_route | output | 3 | One-hot target: bit0 system memory, bit1 downstream memory, bit2 CPU-local |
| ib_err | output | 1 | Inbound address maps to no target |

## Verification
A configuration write and an outbound lookup can occur in the same cycle. The bench drives a write that changes the enable bit or the mode of the chunk under lookup, together with an address in that chunk. It checks the forward decision just after the driving edge against the old register contents, and again one clock later against the new contents. Inbound routing shares no state with the registers, so the bench also confirms that inbound results at region boundaries stay correct while writes are in progress.

// File: rtl/cwd_pkg.sv
`timescale 1ns/1ps
package cwd_pkg;
    localparam int DEF_ADDR_W   = 32;
    localparam int DEF_WIN_LG2  = 28;  // forwarding region: top 256 MiB
    localparam int DEF_CHUNK_LG2 = 23; // 8 MiB chunks
    localparam int DEF_CPU_LG2  = 20;  // 1 MiB CPU-local space
    localparam int DEF_MODE_LSB = 7;   // mode field position in control write
    localparam int MODE_W       = 2;

    typedef enum logic [MODE_W-1:0] {
        FM_OFF  = 2'b00,
        FM_ON   = 2'b01,
        FM_RSV2 = 2'b10,
        FM_RSV3 = 2'b11
    } fwd_mode_e;

    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_CTRL   = 1'b1
    } cfg_sel_e;

    typedef enum logic [1:0] {
        RT_SYS = 2'd0,
        RT_DS  = 2'd1,
        RT_CPU = 2'd2,
        RT_ERR = 2'd3
    } route_e;

    typedef struct packed {
        logic fwd;
        logic loc;
    } ob_result_t;

    function automatic logic [2:0] route_onehot(route_e r);
        case (r)
            RT_SYS:  return 3'b001;
            RT_DS:   return 3'b010;
            RT_CPU:  return 3'b100;
            default: return 3'b000;
        endcase
    endfunction
endpackage

// File: rtl/cwd_cfg_regs.sv
`timescale 1ns/1ps
module cwd_cfg_regs
    import cwd_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_CHUNKS = 32,
    parameter int MODE_LSB   = DEF_MODE_LSB
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  cfg_sel_e              sel,
    input  logic [DATA_W-1:0]     wdata,
    output logic [NUM_CHUNKS-1:0] en_q,
    output fwd_mode_e             mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mode_q <= FM_OFF;
        end else if (we) begin
            if (sel == SEL_ENABLE) en_q <= wdata[NUM_CHUNKS-1:0];
            else                   mode_q <= fwd_mode_e'(wdata[MODE_LSB +: MODE_W]);
        end
    end
endmodule

// File: rtl/cwd_outbound.sv
`timescale 1ns/1ps
module cwd_outbound
    import cwd_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int WIN_LG2   = DEF_WIN_LG2,
    parameter int CHUNK_LG2 = DEF_CHUNK_LG2
) (
    input  logic [ADDR_W-1:0]                       addr,
    input  logic [(1 << (WIN_LG2-CHUNK_LG2))-1:0]   en,
    input  fwd_mode_e                               mode,
    output ob_result_t                              res
);
    localparam int IDX_W      = WIN_LG2 - CHUNK_LG2;
    localparam int NUM_CHUNKS = 1 << IDX_W;
    localparam int TOP_W      = ADDR_W - WIN_LG2;

    logic [NUM_CHUNKS-1:0] usable;
    logic [IDX_W-1:0]      idx;
    logic                  in_win;

    // End chunks are hardwired off; middle chunks follow their enable bit.
    for (genvar i = 0; i < NUM_CHUNKS; i++) begin : g_chunk
        if (i == 0 || i == NUM_CHUNKS-1) begin : g_end
            assign usable[i] = 1'b0;
        end else begin : g_mid
            assign usable[i] = en[i];
        end
    end

    assign in_win = &addr[ADDR_W-1 -: TOP_W];
    assign idx    = addr[WIN_LG2-1:CHUNK_LG2];

    always_comb begin
        res.fwd = (mode == FM_ON) && in_win && usable[idx];
        res.loc = !res.fwd;
    end

    logic unused_ob;
    assign unused_ob = ^{en[0], en[NUM_CHUNKS-1], addr[CHUNK_LG2-1:0]};
endmodule

// File: rtl/cwd_inbound.sv
`timescale 1ns/1ps
module cwd_inbound
    import cwd_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int WIN_LG2   = DEF_WIN_LG2,
    parameter int CHUNK_LG2 = DEF_CHUNK_LG2,
    parameter int CPU_LG2   = DEF_CPU_LG2
) (
    input  logic [ADDR_W-1:0] addr,
    output route_e            route
);
    localparam int NUM_CHUNKS = 1 << (WIN_LG2 - CHUNK_LG2);
    localparam logic [ADDR_W-1:0] ALL1     = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] WIN_BASE = ALL1 << WIN_LG2;
    localparam logic [ADDR_W-1:0] CHUNK_SZ = ADDR_W'(1) << CHUNK_LG2;
    localparam logic [ADDR_W-1:0] DS_LO    = WIN_BASE + CHUNK_SZ;
    localparam logic [ADDR_W-1:0] DS_END   = WIN_BASE + ADDR_W'(NUM_CHUNKS-1) * CHUNK_SZ;
    localparam logic [ADDR_W-1:0] CPU_LO   = ALL1 << CPU_LG2;

    always_comb begin
        if (addr < DS_LO)        route = RT_SYS;
        else if (addr < DS_END)  route = RT_DS;
        else if (addr >= CPU_LO) route = RT_CPU;
        else                     route = RT_ERR;
    end
endmodule

// File: rtl/chunk_window_decoder.sv
`timescale 1ns/1ps
module chunk_window_decoder
    import cwd_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int WIN_LG2   = DEF_WIN_LG2,
    parameter int CHUNK_LG2 = DEF_CHUNK_LG2,
    parameter int CPU_LG2   = DEF_CPU_LG2,
    parameter int MODE_LSB  = DEF_MODE_LSB,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] ob_addr,
    output logic              ob_fwd,
    output logic              ob_local,
    input  logic [ADDR_W-1:0] ib_addr,
    output logic [2:0]        ib_route,
    output logic              ib_err
);
    localparam int NUM_CHUNKS = 1 << (WIN_LG2 - CHUNK_LG2);

    logic [NUM_CHUNKS-1:0] en_q;
    fwd_mode_e             mode_q;
    ob_result_t            ob_res;
    route_e                ib_rt;

    cwd_cfg_regs #(
        .DATA_W(DATA_W), .NUM_CHUNKS(NUM_CHUNKS), .MODE_LSB(MODE_LSB)
    ) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel_e'(cfg_sel)),
        .wdata(cfg_wdata), .en_q(en_q), .mode_q(mode_q)
    );

    cwd_outbound #(
        .ADDR_W(ADDR_W), .WIN_LG2(WIN_LG2), .CHUNK_LG2(CHUNK_LG2)
    ) u_ob (
        .addr(ob_addr), .en(en_q), .mode(mode_q), .res(ob_res)
    );

    cwd_inbound #(
        .ADDR_W(ADDR_W), .WIN_LG2(WIN_LG2), .CHUNK_LG2(CHUNK_LG2), .CPU_LG2(CPU_LG2)
    ) u_ib (
        .addr(ib_addr), .route(ib_rt)
    );

    assign ob_fwd   = ob_res.fwd;
    assign ob_local = ob_res.loc;
    assign ib_route = route_onehot(ib_rt);
    assign ib_err   = (ib_rt == RT_ERR);
endmodule

// File: rtl/chunk_window_decoder_chk.sv
`timescale 1ns/1ps
module chunk_window_decoder_chk
    import cwd_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int WIN_LG2    = DEF_WIN_LG2,
    parameter int CHUNK_LG2  = DEF_CHUNK_LG2,
    parameter int CPU_LG2    = DEF_CPU_LG2,
    parameter int DATA_W     = 32,
    parameter int NUM_CHUNKS = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cfg_we,
    input logic                  cfg_sel,
    input logic [DATA_W-1:0]     cfg_wdata,
    input logic [ADDR_W-1:0]     ob_addr,
    input logic                  ob_fwd,
    input logic [ADDR_W-1:0]     ib_addr,
    input logic [2:0]            ib_route,
    input logic                  ib_err,
    input logic [NUM_CHUNKS-1:0] en_q,
    input logic [MODE_W-1:0]     mode_q
);
    localparam logic [ADDR_W-1:0] WIN_BASE = {ADDR_W{1'b1}} << WIN_LG2;
    localparam logic [ADDR_W-1:0] CPU_LO   = {ADDR_W{1'b1}} << CPU_LG2;
    localparam int IDX_W = WIN_LG2 - CHUNK_LG2;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == '0 && mode_q == '0));                                   // R1
    AST_MODE_GATE: assert property (@(posedge clk) disable iff (rst)
        ob_fwd |-> mode_q == 2'b01);                                                     // R2
    AST_END_CHUNKS: assert property (@(posedge clk) disable iff (rst)
        ob_fwd |-> (ob_addr[WIN_LG2-1:CHUNK_LG2] != '0 &&
                    ob_addr[WIN_LG2-1:CHUNK_LG2] != {IDX_W{1'b1}}));                     // R4
    AST_LOW_NEVER: assert property (@(posedge clk) disable iff (rst)
        ob_fwd |-> ob_addr >= WIN_BASE);                                                 // R5
    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_we) && !$past(cfg_sel))
            |-> en_q == $past(cfg_wdata[NUM_CHUNKS-1:0]));                               // R7
    AST_CTRL_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_we) && $past(cfg_sel)) |-> $stable(en_q));             // R12
    AST_CPU_REGION: assert property (@(posedge clk) disable iff (rst)
        ib_route[2] |-> ib_addr >= CPU_LO);                                              // R10
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $countones({ib_route, ib_err}) == 1);                                            // R11
endmodule

bind chunk_window_decoder chunk_window_decoder_chk #(
    .ADDR_W(ADDR_W), .WIN_LG2(WIN_LG2), .CHUNK_LG2(CHUNK_LG2),
    .CPU_LG2(CPU_LG2), .DATA_W(DATA_W), .NUM_CHUNKS(NUM_CHUNKS)
) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ob_addr(ob_addr), .ob_fwd(ob_fwd), .ib_addr(ib_addr), .ib_route(ib_route),
    .ib_err(ib_err), .en_q(en_q), .mode_q(mode_q)
);

// File: tb/sim_chunk_window_decoder.sv
`timescale 1ns/1ps
module sim_chunk_window_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] ob_addr = '0;
    logic [31:0] ib_addr = '0;
    logic        ob_fwd, ob_local, ib_err;
    logic [2:0]  ib_route;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    chunk_window_decoder u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ob_addr(ob_addr), .ob_fwd(ob_fwd), .ob_local(ob_local),
        .ib_addr(ib_addr), .ib_route(ib_route), .ib_err(ib_err)
    );

    localparam logic [31:0] BASE  = 32'hF000_0000;
    localparam logic [31:0] CHUNK = 32'h0080_0000;

    function automatic bit exp_fwd(logic [31:0] en, logic [1:0] mode, logic [31:0] a);
        int unsigned idx;
        if (mode != 2'b01) return 1'b0;
        if (a < BASE) return 1'b0;
        idx = (a - BASE) / CHUNK;
        if (idx == 0 || idx == 31) return 1'b0;
        return en[idx];
    endfunction

    // returns {err, route[2:0]}
    function automatic logic [3:0] exp_ib(logic [31:0] a);
        if (a < BASE + CHUNK)              return 4'b0001;
        if (a < BASE + 31 * CHUNK)         return 4'b0010;
        if (a >= 32'hFFF0_0000)            return 4'b0100;
        return 4'b1000;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cfg(bit sel, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic ob_probe(string req, logic [31:0] en, logic [1:0] mode, logic [31:0] a);
        bit e;
        ob_addr = a;
        #1;
        e = exp_fwd(en, mode, a);
        check(req, {31'd0, ob_fwd}, {31'd0, e});
        check("R6", {31'd0, ob_local}, {31'd0, !e});
    endtask

    task automatic ib_probe(logic [31:0] a);
        logic [3:0] e;
        string r;
        ib_addr = a;
        #1;
        e = exp_ib(a);
        r = e[3] ? "R11" : e[2] ? "R10" : e[1] ? "R9" : "R8";
        check(r, {28'd0, ib_err, ib_route}, {28'd0, e});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [5];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hAAAA_5555;
        pats[3] = 32'h8000_0001; pats[4] = 32'h7FFF_FFFE;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: after reset, nothing forwards even in enabled-looking windows
        for (int c = 0; c < 32; c++) ob_probe("R1", 32'h0, 2'b00, BASE + c * CHUNK);

        // R2 R3 R4 R5 R12: sweep enable patterns and all four mode values
        for (int p = 0; p < 5; p++) begin
            write_cfg(1'b0, pats[p]);
            for (int m = 0; m < 4; m++) begin
                // junk outside bits 8:7 must not matter; R12: enable kept
                write_cfg(1'b1, (32'h5A5A_A5A5 & ~32'h180) | (32'(m) << 7));
                for (int c = 0; c < 32; c++) begin
                    string rq;
                    rq = (m != 1) ? "R2" : (c == 0 || c == 31) ? "R4" : "R3";
                    ob_probe(rq, pats[p], 2'(m), BASE + c * CHUNK);
                    ob_probe(rq, pats[p], 2'(m), BASE + (c + 1) * CHUNK - 1);
                end
                ob_probe("R5", pats[p], 2'(m), 32'h0000_0000);
                ob_probe("R5", pats[p], 2'(m), 32'h1234_5678);
                ob_probe("R5", pats[p], 2'(m), 32'hEFFF_FFFF);
            end
        end

        // R7: same-cycle write and lookup, chunk 5
        write_cfg(1'b0, 32'h0000_0000);
        write_cfg(1'b1, 32'h0000_0080);
        @(negedge clk);
        ob_addr = BASE + 5 * CHUNK + 32'h100;
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h0000_0020;
        ib_addr = 32'hF080_0000;
        #1;
        check("R7", {31'd0, ob_fwd}, 32'd0);      // old enable still active
        check("R9", {28'd0, ib_err, ib_route}, 32'h2);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check("R7", {31'd0, ob_fwd}, 32'd1);      // new enable visible
        // mode change in same cycle as lookup
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'h0000_0100;
        #1;
        check("R7", {31'd0, ob_fwd}, 32'd1);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check("R7", {31'd0, ob_fwd}, 32'd0);
        check("R12", {31'd0, ob_fwd}, 32'd0);

        // R8..R11: inbound boundaries and interior points
        ib_probe(32'h0000_0000); ib_probe(32'h8000_0000); ib_probe(32'hF07F_FFFF);
        ib_probe(32'hF080_0000); ib_probe(32'hF800_0000); ib_probe(32'hFF7F_FFFF);
        ib_probe(32'hFF80_0000); ib_probe(32'hFFAB_CDEF); ib_probe(32'hFFEF_FFFF);
        ib_probe(32'hFFF0_0000); ib_probe(32'hFFF8_1234); ib_probe(32'hFFFF_FFFF);
        for (int c = 0; c < 32; c++) begin
            ib_probe(BASE + c * CHUNK);
            ib_probe(BASE + c * CHUNK + 32'h0007_FFFF);
        end

        // R1: reset mid-run clears registers again
        write_cfg(1'b0, 32'hFFFF_FFFF);
        write_cfg(1'b1, 32'h0000_0080);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        ob_probe("R1", 32'h0, 2'b00, BASE + 3 * CHUNK);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule